// File: doc/BRIEF.md
# FIFO Watermark Transfer Request Generator

This block sits beside the shared data FIFO of a card host controller and decides when the DMA engine, or the processor in interrupt mode, should move data. When sending toward the card it asks for refills once the FIFO runs low. When receiving it asks for draining once the FIFO holds enough data. Two 12-bit watermarks and a 3-bit burst-size code arrive in one 32-bit configuration word.

In DMA mode the block raises either a burst request or a single-transfer request. A raised request is held until the DMA side acknowledges it. In interrupt mode the DMA requests stay low and a per-direction threshold flag is raised instead.

Near the end of a packet, override rules apply. Transmit requests are raised whatever the watermark says. A remainder shorter than one burst is moved with single transfers. A command-completion-signal timeout cancels that final flush. A one-cycle done pulse marks the point where the remaining count has reached zero and no request is outstanding.

Top module: `fifo_wm_dreq`

## Requirements
- R1: The configuration word is decoded by position. Bits 11:0 are the transmit watermark, bits 27:16 are the receive watermark, and bits 30:28 are the burst code. Code 0 means 1 beat and code n (1 to 7) means 2^(n+1) beats (4, 8, 16, 32, 64, 128, 256).
- R2: In DMA mode, transmit direction (rx_dir=0), with beats_left nonzero and no end of packet, burst_req rises on the clock edge after fifo_level is less than or equal to the transmit watermark. It stays low while fifo_level is above it.
- R3: In DMA mode, receive direction (rx_dir=1), burst_req rises on the clock edge after fifo_level is strictly greater than the receive watermark. It stays low at equality.
- R4: A raised burst_req or single_req holds until dma_ack is sampled high. At that edge it drops, and the request is evaluated again on the following edge from the inputs present then.
- R5: In interrupt mode (dma_mode=0), burst_req and single_req stay low. tx_irq or rx_irq follows the same watermark test for its direction, registered one edge after the inputs. It is recomputed every cycle and needs no acknowledge.
- R6: In transmit direction with pkt_end high and beats_left nonzero, a request is made regardless of the watermark. In DMA mode this is a burst when beats_left is at least one burst. In interrupt mode it is tx_irq.
- R7: In DMA mode with pkt_end high and beats_left nonzero but below one burst, single_req is raised instead of burst_req. In receive direction this also needs fifo_level to be nonzero.
- R8: In interrupt mode, receive direction, with pkt_end high and fifo_level not above the watermark, rx_irq is raised only when the receive watermark is at most beats_left and fifo_level is nonzero.
- R9: In DMA mode with ccs_timeout high, the end-of-packet overrides of R6 and R7 are suppressed. Only the plain watermark tests of R2 and R3 can raise a request.
- R10: xfer_done pulses for exactly one cycle, on the edge after beats_left is zero and no request is pending, provided beats_left was nonzero at some edge since the last pulse or reset.
- R11: After reset all outputs are low, and burst_req and single_req are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Watermarks and burst code |
| fifo_level | input | 13 | Current FIFO fill count |
| rx_dir | input | 1 | 1 = receive (drain), 0 = transmit (refill) |
| dma_mode | input | 1 | 1 = DMA requests, 0 = interrupt flags |
| beats_left | input | 16 | Transfers still to move in this packet |
| pkt_end | input | 1 | End-of-packet phase indication |
| ccs_timeout | input | 1 | Command-completion-signal timeout |
| dma_ack | input | 1 | DMA side accepts the pending request |
| burst_req | output | 1 | Burst transfer request |
| single_req | output | 1 | Single transfer request |
| tx_irq | output | 1 | Transmit threshold interrupt flag |
| rx_irq | output | 1 | Receive threshold interrupt flag |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |

## Verification
Two events can fall in the same cycle: the acknowledge of the last single transfer and the remaining count dropping to zero. Because the request is still pending in that cycle, the done pulse must not appear on that edge. The bench drives beats_left to zero together with dma_ack. It then checks that xfer_done stays low on the acknowledge edge, rises on the next edge, and falls again one edge later. A second overlap, an acknowledge while the watermark condition still holds, is judged by checking that the request drops for one cycle and then returns.

// File: rtl/fifo_wm_dreq_pkg.sv
package fifo_wm_dreq_pkg;
  localparam int WM_W    = 12;
  localparam int LVL_W   = WM_W + 1;
  localparam int CODE_W  = 3;
  localparam int BEAT_W  = (1 << CODE_W) + 1;
  localparam int LEFT_W  = 16;

  localparam int TXWM_LSB = 0;
  localparam int RXWM_LSB = 16;
  localparam int CODE_LSB = 28;

  typedef struct packed {
    logic [WM_W-1:0]   tx_wm;
    logic [WM_W-1:0]   rx_wm;
    logic [CODE_W-1:0] code;
  } wm_cfg_t;

  function automatic wm_cfg_t split_cfg(input logic [31:0] w);
    wm_cfg_t c;
    c.tx_wm = w[TXWM_LSB +: WM_W];
    c.rx_wm = w[RXWM_LSB +: WM_W];
    c.code  = w[CODE_LSB +: CODE_W];
    return c;
  endfunction

  // code 0 -> one beat, code n -> 2^(n+1) beats
  function automatic logic [BEAT_W-1:0] beats_of(input logic [CODE_W-1:0] c);
    logic [CODE_W:0] sh;
    sh = {1'b0, c} + 1'b1;
    if (c == '0) return BEAT_W'(1);
    return BEAT_W'(1) << sh;
  endfunction
endpackage

// File: rtl/fifo_wm_cfg_dec.sv
module fifo_wm_cfg_dec
  import fifo_wm_dreq_pkg::*;
(
  input  logic [31:0]       cfg_word,
  output logic [WM_W-1:0]   tx_wm,
  output logic [WM_W-1:0]   rx_wm,
  output logic [BEAT_W-1:0] burst_len
);
  wm_cfg_t cfg;
  logic    unused_cfg_bits;

  assign cfg             = split_cfg(cfg_word);
  assign tx_wm           = cfg.tx_wm;
  assign rx_wm           = cfg.rx_wm;
  assign burst_len       = beats_of(cfg.code);
  assign unused_cfg_bits = ^{cfg_word[31], cfg_word[15:12]};
endmodule

// File: rtl/fifo_wm_cmp.sv
module fifo_wm_cmp
  import fifo_wm_dreq_pkg::*;
(
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [WM_W-1:0]   tx_wm,
  input  logic [WM_W-1:0]   rx_wm,
  input  logic [BEAT_W-1:0] burst_len,
  input  logic [LEFT_W-1:0] beats_left,
  input  logic              rx_dir,
  input  logic              dma_mode,
  input  logic              pkt_end,
  input  logic              ccs_timeout,
  output logic              tx_hit,
  output logic              rx_hit,
  output logic              eop_short,
  output logic              want_burst,
  output logic              want_single,
  output logic              want_tx_irq,
  output logic              want_rx_irq
);
  logic have_left;
  logic have_data;
  logic eop_dma;
  logic rx_eop_fits;

  assign have_left   = (beats_left != '0);
  assign have_data   = (fifo_level != '0);
  assign tx_hit      = fifo_level <= LVL_W'(tx_wm);
  assign rx_hit      = fifo_level >  LVL_W'(rx_wm);
  assign eop_short   = beats_left < LEFT_W'(burst_len);
  assign eop_dma     = dma_mode && pkt_end && !ccs_timeout && have_left;
  assign rx_eop_fits = LEFT_W'(rx_wm) <= beats_left;

  always_comb begin
    want_single = eop_dma && eop_short && (rx_dir ? have_data : 1'b1);
    want_burst  = 1'b0;
    if (dma_mode && have_left && !want_single) begin
      if (rx_dir) want_burst = rx_hit;
      else        want_burst = tx_hit || eop_dma;
    end
  end

  always_comb begin
    want_tx_irq = 1'b0;
    want_rx_irq = 1'b0;
    if (!dma_mode) begin
      if (rx_dir)
        want_rx_irq = rx_hit || (pkt_end && have_data && have_left && rx_eop_fits);
      else
        want_tx_irq = have_left && (tx_hit || pkt_end);
    end
  end
endmodule

// File: rtl/fifo_wm_req_ctl.sv
module fifo_wm_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic want_burst,
  input  logic want_single,
  input  logic want_tx_irq,
  input  logic want_rx_irq,
  input  logic dma_ack,
  output logic burst_q,
  output logic single_q,
  output logic tx_irq_q,
  output logic rx_irq_q,
  output logic pending
);
  assign pending = burst_q | single_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q  <= 1'b0;
      single_q <= 1'b0;
      tx_irq_q <= 1'b0;
      rx_irq_q <= 1'b0;
    end else begin
      if (pending) begin
        if (dma_ack) begin
          burst_q  <= 1'b0;
          single_q <= 1'b0;
        end
      end else begin
        burst_q  <= want_burst;
        single_q <= want_single;
      end
      tx_irq_q <= want_tx_irq;
      rx_irq_q <= want_rx_irq;
    end
  end
endmodule

// File: rtl/fifo_wm_done.sv
module fifo_wm_done
  import fifo_wm_dreq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEFT_W-1:0] beats_left,
  input  logic              pending,
  output logic              done_q
);
  logic armed_q;
  logic finish_now;

  assign finish_now = armed_q && (beats_left == '0) && !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish_now;
      if (beats_left != '0) armed_q <= 1'b1;
      else if (finish_now)  armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_wm_dreq.sv
module fifo_wm_dreq
  import fifo_wm_dreq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              rx_dir,
  input  logic              dma_mode,
  input  logic [LEFT_W-1:0] beats_left,
  input  logic              pkt_end,
  input  logic              ccs_timeout,
  input  logic              dma_ack,
  output logic              burst_req,
  output logic              single_req,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              xfer_done
);
  logic [WM_W-1:0]   tx_wm;
  logic [WM_W-1:0]   rx_wm;
  logic [BEAT_W-1:0] burst_len;
  logic tx_hit, rx_hit, eop_short;
  logic want_burst, want_single, want_tx_irq, want_rx_irq;
  logic req_pending;

  fifo_wm_cfg_dec u_dec (
    .cfg_word (cfg_word),
    .tx_wm    (tx_wm),
    .rx_wm    (rx_wm),
    .burst_len(burst_len)
  );

  fifo_wm_cmp u_cmp (
    .fifo_level (fifo_level),
    .tx_wm      (tx_wm),
    .rx_wm      (rx_wm),
    .burst_len  (burst_len),
    .beats_left (beats_left),
    .rx_dir     (rx_dir),
    .dma_mode   (dma_mode),
    .pkt_end    (pkt_end),
    .ccs_timeout(ccs_timeout),
    .tx_hit     (tx_hit),
    .rx_hit     (rx_hit),
    .eop_short  (eop_short),
    .want_burst (want_burst),
    .want_single(want_single),
    .want_tx_irq(want_tx_irq),
    .want_rx_irq(want_rx_irq)
  );

  fifo_wm_req_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .want_burst (want_burst),
    .want_single(want_single),
    .want_tx_irq(want_tx_irq),
    .want_rx_irq(want_rx_irq),
    .dma_ack    (dma_ack),
    .burst_q    (burst_req),
    .single_q   (single_req),
    .tx_irq_q   (tx_irq),
    .rx_irq_q   (rx_irq),
    .pending    (req_pending)
  );

  fifo_wm_done u_done (
    .clk       (clk),
    .rst_n     (rst_n),
    .beats_left(beats_left),
    .pending   (req_pending),
    .done_q    (xfer_done)
  );
endmodule

// File: rtl/fifo_wm_dreq_chk.sv
module fifo_wm_dreq_chk (
  input logic clk,
  input logic rst_n,
  input logic dma_mode,
  input logic dma_ack,
  input logic burst_req,
  input logic single_req,
  input logic tx_irq,
  input logic rx_irq,
  input logic xfer_done,
  input logic req_pending
);
  // R11
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst_req && single_req));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pending && !dma_ack) |=> (burst_req == $past(burst_req)) && (single_req == $past(single_req)));

  // R4
  req_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pending && dma_ack) |=> !burst_req && !single_req);

  // R5
  irq_mode_no_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_mode && !req_pending) |=> !burst_req && !single_req);

  // R5
  dma_mode_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode |=> !tx_irq && !rx_irq);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pending |=> !xfer_done);
endmodule

bind fifo_wm_dreq fifo_wm_dreq_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dma_mode   (dma_mode),
  .dma_ack    (dma_ack),
  .burst_req  (burst_req),
  .single_req (single_req),
  .tx_irq     (tx_irq),
  .rx_irq     (rx_irq),
  .xfer_done  (xfer_done),
  .req_pending(req_pending)
);

// File: tb/test_fifo_wm_dreq.sv
module test_fifo_wm_dreq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [12:0] fifo_level = '0;
  logic        rx_dir = 1'b0;
  logic        dma_mode = 1'b1;
  logic [15:0] beats_left = '0;
  logic        pkt_end = 1'b0;
  logic        ccs_timeout = 1'b0;
  logic        dma_ack = 1'b0;
  logic        burst_req, single_req, tx_irq, rx_irq, xfer_done;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  fifo_wm_dreq i_fifo_wm_dreq (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .fifo_level(fifo_level),
    .rx_dir(rx_dir), .dma_mode(dma_mode), .beats_left(beats_left),
    .pkt_end(pkt_end), .ccs_timeout(ccs_timeout), .dma_ack(dma_ack),
    .burst_req(burst_req), .single_req(single_req), .tx_irq(tx_irq),
    .rx_irq(rx_irq), .xfer_done(xfer_done)
  );

  function automatic logic [31:0] mk_cfg(int txw, int rxw, int code);
    return (32'(code) << 28) | (32'(rxw) << 16) | 32'(txw);
  endfunction

  function automatic int beats(int code);
    int r = 1;
    for (int i = 0; i <= code; i++) if (i > 0 || code > 0) r = r * 2;
    return (code == 0) ? 1 : r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ack_once();
    dma_ack = 1'b1; step(); dma_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 reset burst", burst_req, 0);
    chk("R11 reset single", single_req, 0);
    chk("R11 reset irqs", {tx_irq, rx_irq}, 0);
    chk("R11 reset done", xfer_done, 0);
  endtask

  task automatic t_tx_burst();
    cfg_word = mk_cfg(8, 7, 2); dma_mode = 1; rx_dir = 0; pkt_end = 0;
    beats_left = 100; fifo_level = 9; step();
    chk("R2 tx above wm", burst_req, 0);
    fifo_level = 8; step();
    chk("R2 tx equal wm", burst_req, 1);
    fifo_level = 20; step();
    chk("R4 hold without ack", burst_req, 1);
    ack_once();
    chk("R4 cleared by ack", burst_req, 0);
    step();
    chk("R4 reeval stays low", burst_req, 0);
    fifo_level = 3; step();
    chk("R2 tx below wm", burst_req, 1);
    chk("R11 exclusive", burst_req & single_req, 0);
    fifo_level = 100; ack_once();
    cfg_word = mk_cfg(300, 1000, 2); fifo_level = 301; step();
    chk("R1 tx field 301", burst_req, 0);
    fifo_level = 300; step();
    chk("R1 tx field 300", burst_req, 1);
    fifo_level = 400; ack_once(); step();
  endtask

  task automatic t_rx_burst();
    cfg_word = mk_cfg(8, 7, 2); rx_dir = 1; dma_mode = 1; pkt_end = 0;
    beats_left = 100; fifo_level = 7; step();
    chk("R3 rx equal wm", burst_req, 0);
    fifo_level = 8; step();
    chk("R3 rx above wm", burst_req, 1);
    dma_ack = 1; step(); dma_ack = 0;
    chk("R4 rx ack clears", burst_req, 0);
    step();
    chk("R4 rx reraised", burst_req, 1);
    fifo_level = 0; ack_once(); step();
    chk("R3 rx empty", burst_req, 0);
  endtask

  task automatic t_codes();
    rx_dir = 0; dma_mode = 1; pkt_end = 1; ccs_timeout = 0; fifo_level = 100;
    for (int c = 0; c < 8; c++) begin
      cfg_word = mk_cfg(8, 7, c);
      beats_left = 16'(beats(c)); step();
      chk($sformatf("R1 R6 code%0d full burst", c), {burst_req, single_req}, 2);
      ack_once();
      if (c > 0) begin
        beats_left = 16'(beats(c) - 1); step();
        chk($sformatf("R1 R7 code%0d short single", c), {burst_req, single_req}, 1);
        ack_once();
      end
    end
    pkt_end = 0; beats_left = 100; step();
  endtask

  task automatic t_rx_single_ccs();
    cfg_word = mk_cfg(8, 7, 2); dma_mode = 1;
    rx_dir = 1; pkt_end = 1; beats_left = 3; fifo_level = 3; step();
    chk("R7 rx short single", single_req, 1);
    fifo_level = 0; ack_once(); step();
    chk("R7 rx empty no single", single_req, 0);
    ccs_timeout = 1; fifo_level = 3; step();
    chk("R9 rx ccs no flush", {burst_req, single_req}, 0);
    fifo_level = 10; step();
    chk("R9 rx ccs wm still works", burst_req, 1);
    fifo_level = 0; ack_once();
    rx_dir = 0; fifo_level = 100; step();
    chk("R9 tx ccs no eop request", {burst_req, single_req}, 0);
    ccs_timeout = 0; pkt_end = 0; beats_left = 100; step();
  endtask

  task automatic t_irq_mode();
    cfg_word = mk_cfg(8, 7, 2); dma_mode = 0; rx_dir = 0; pkt_end = 0;
    beats_left = 100; fifo_level = 5; step();
    chk("R5 tx irq", tx_irq, 1);
    chk("R5 no dma in irq mode", {burst_req, single_req}, 0);
    fifo_level = 9; step();
    chk("R5 tx irq drops", tx_irq, 0);
    pkt_end = 1; fifo_level = 50; step();
    chk("R6 tx eop irq", tx_irq, 1);
    pkt_end = 0; rx_dir = 1; fifo_level = 8; step();
    chk("R5 rx irq", {tx_irq, rx_irq}, 1);
    pkt_end = 1; fifo_level = 3; beats_left = 5; step();
    chk("R8 rx wm above left", rx_irq, 0);
    beats_left = 7; step();
    chk("R8 rx wm equals left", rx_irq, 1);
    beats_left = 10; fifo_level = 0; step();
    chk("R8 rx empty", rx_irq, 0);
    pkt_end = 0; dma_mode = 1; fifo_level = 0; beats_left = 100; step();
  endtask

  task automatic t_done();
    cfg_word = mk_cfg(8, 7, 2); dma_mode = 1; rx_dir = 0; pkt_end = 0;
    beats_left = 4; fifo_level = 100; step();
    chk("R10 no done while left", xfer_done, 0);
    pkt_end = 1; step();
    chk("R10 R7 last single", single_req, 1);
    beats_left = 0; dma_ack = 1; step(); dma_ack = 0;
    chk("R10 no done on ack edge", xfer_done, 0);
    step();
    chk("R10 done pulse", xfer_done, 1);
    step();
    chk("R10 done one cycle", xfer_done, 0);
    pkt_end = 0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_tx_burst();
    t_rx_burst();
    t_codes();
    t_rx_single_ccs();
    t_irq_mode();
    t_done();
    finish_run();
  end
endmodule